// File: doc/BRIEF.md
# Windowed Watchdog with Data-Match Service

This block supervises software by means of an 8-bit down-counter that has to be serviced regularly. A service is a single-cycle write that carries a data byte. The service is accepted only when two conditions hold: the counter has already fallen to or below a programmed window threshold, and the byte equals a programmed key. An accepted service reloads the counter from a programmed reload value.

Three kinds of fault are detected. A service that arrives too soon, a counter that runs out before any service, and a service with the wrong key each set a separate sticky flag. The OR of the three flags drives a single error line, which is meant for a non-maskable interrupt or a reset generator. After any fault the counter reloads, so it is left in a defined state.

The counter is advanced by a tick from an internal prescaler, and a 2-bit selector picks how often that tick comes. Software can write the configuration and set a lock with the same write. Once the lock is set, later configuration writes are ignored until reset. A debug freeze input holds both the counter and the prescaler.

Top module: `wdw_top`

## Requirements
- R1: While reset is asserted, the count equals the reset reload value (default 255). All three error flags, the error line and the lock indication are 0.
- R2: When not frozen, the count drops by one on each tick. Selector value s (0 to 3) gives one tick every 2^s clock cycles, counted from the last accepted configuration write. With s = 2 the first decrement happens on the 4th clock edge after that write.
- R3: A service while count <= window and with data equal to the key reloads the count from the reload value on the next edge and sets no flag.
- R4: A service while count > window sets the early flag and reloads the count.
- R5: A service whose data differs from the key sets the data flag and reloads the count.
- R6: A service that is both early and carries a wrong key sets both the early flag and the data flag.
- R7: A tick while the count is 0, with no service in the same cycle, sets the late flag and reloads the count.
- R8: Each flag stays set until reset. The error line is the OR of the three flags.
- R9: An accepted configuration write updates the reload value, window, key and selector. It loads the count with the new reload value, restarts the prescaler, and sets the lock when the lock input is 1.
- R10: While locked, configuration writes have no effect: the count, the reload value, the window and the key are all kept. Only reset clears the lock.
- R11: While freeze is high, the count and the prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_preload | input | 8 | Reload value to write |
| cfg_window | input | 8 | Window threshold to write |
| cfg_match | input | 8 | Service key to write |
| cfg_tick_sel | input | 2 | Tick rate selector to write |
| cfg_lock | input | 1 | Set lock with this write |
| svc_we | input | 1 | Service strobe |
| svc_data | input | 8 | Service data byte |
| dbg_freeze | input | 1 | Debug freeze |
| wd_count | output | 8 | Current counter value |
| wd_locked | output | 1 | Configuration is locked |
| err_early | output | 1 | Sticky early-service flag |
| err_late | output | 1 | Sticky expiry flag |
| err_data | output | 1 | Sticky wrong-key flag |
| wd_err | output | 1 | Combined watchdog error |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 2-bit tick selector and a reset reload value of 255. It then programs small reload values, such as 5 and 20, so that counter expiry and the boundary of the service window can be reached within a few dozen cycles. With selector value 2, it checks the exact clock edge of each prescaled decrement. It also checks that the prescaler phase is kept across a freeze.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
    localparam int CNT_W = 8;
    localparam int SEL_W = 2;
    localparam int PRE_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] preload;
        logic [CNT_W-1:0] window;
        logic [CNT_W-1:0] match;
        logic [SEL_W-1:0] sel;
    } wdw_cfg_t;

    typedef struct packed {
        logic early;
        logic late;
        logic data;
    } wdw_flags_t;

    function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] sel);
        logic [PRE_W-1:0] m;
        for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(sel));
        return m;
    endfunction
endpackage

// File: rtl/wdw_prescaler.sv
module wdw_prescaler
    import wdw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             freeze,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || restart) pre_q <= '0;
        else if (!freeze)   pre_q <= pre_q + 1'b1;
    end

    assign tick = &(pre_q | ~tap_mask(sel));
endmodule

// File: rtl/wdw_cfg_regs.sv
module wdw_cfg_regs
    import wdw_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_PRELOAD = 8'hFF,
    parameter logic [CNT_W-1:0] RST_WINDOW  = 8'h7F,
    parameter logic [CNT_W-1:0] RST_MATCH   = 8'hA5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  wdw_cfg_t wr_cfg,
    input  logic     wr_lock,
    output wdw_cfg_t cfg_q,
    output logic     locked_q,
    output logic     accept
);
    assign accept = wr && !locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.preload <= RST_PRELOAD;
            cfg_q.window  <= RST_WINDOW;
            cfg_q.match   <= RST_MATCH;
            cfg_q.sel     <= '0;
            locked_q      <= 1'b0;
        end else if (accept) begin
            cfg_q    <= wr_cfg;
            locked_q <= wr_lock;
        end
    end
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
    import wdw_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_PRELOAD = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  wdw_cfg_t         cfg,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cfg_new_preload,
    input  logic             tick,
    input  logic             freeze,
    input  logic             svc,
    input  logic [CNT_W-1:0] svc_data,
    output logic [CNT_W-1:0] count_q,
    output wdw_flags_t       flags_q
);
    logic is_early, is_bad, expire;

    assign is_early = count_q > cfg.window;
    assign is_bad   = svc_data != cfg.match;
    assign expire   = tick && !freeze && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= RST_PRELOAD;
            flags_q <= '0;
        end else if (svc) begin
            flags_q.early <= flags_q.early | is_early;
            flags_q.data  <= flags_q.data  | is_bad;
            count_q       <= cfg.preload;
        end else if (cfg_load) begin
            count_q <= cfg_new_preload;
        end else if (expire) begin
            flags_q.late <= 1'b1;
            count_q      <= cfg.preload;
        end else if (tick && !freeze) begin
            count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdw_top.sv
module wdw_top
    import wdw_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_PRELOAD = 8'hFF,
    parameter logic [CNT_W-1:0] RST_WINDOW  = 8'h7F,
    parameter logic [CNT_W-1:0] RST_MATCH   = 8'hA5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_preload,
    input  logic [CNT_W-1:0] cfg_window,
    input  logic [CNT_W-1:0] cfg_match,
    input  logic [SEL_W-1:0] cfg_tick_sel,
    input  logic             cfg_lock,
    input  logic             svc_we,
    input  logic [CNT_W-1:0] svc_data,
    input  logic             dbg_freeze,
    output logic [CNT_W-1:0] wd_count,
    output logic             wd_locked,
    output logic             err_early,
    output logic             err_late,
    output logic             err_data,
    output logic             wd_err
);
    wdw_cfg_t   wr_cfg, cfg_q;
    wdw_flags_t flags;
    logic       cfg_ok, tick;
    logic [CNT_W-1:0] cur_preload, cur_window, cur_match;

    assign wr_cfg = '{preload: cfg_preload, window: cfg_window,
                      match: cfg_match, sel: cfg_tick_sel};

    wdw_cfg_regs #(
        .RST_PRELOAD(RST_PRELOAD), .RST_WINDOW(RST_WINDOW), .RST_MATCH(RST_MATCH)
    ) regs_i (
        .clk(clk), .rst(rst), .wr(cfg_we), .wr_cfg(wr_cfg), .wr_lock(cfg_lock),
        .cfg_q(cfg_q), .locked_q(wd_locked), .accept(cfg_ok)
    );

    wdw_prescaler pre_i (
        .clk(clk), .rst(rst), .restart(cfg_ok), .freeze(dbg_freeze),
        .sel(cfg_q.sel), .tick(tick)
    );

    wdw_counter #(.RST_PRELOAD(RST_PRELOAD)) cnt_i (
        .clk(clk), .rst(rst), .cfg(cfg_q), .cfg_load(cfg_ok),
        .cfg_new_preload(cfg_preload), .tick(tick), .freeze(dbg_freeze),
        .svc(svc_we), .svc_data(svc_data), .count_q(wd_count), .flags_q(flags)
    );

    assign cur_preload = cfg_q.preload;
    assign cur_window  = cfg_q.window;
    assign cur_match   = cfg_q.match;
    assign err_early   = flags.early;
    assign err_late    = flags.late;
    assign err_data    = flags.data;
    assign wd_err      = flags.early | flags.late | flags.data;
endmodule

// File: rtl/wdw_checker.sv
module wdw_checker
    import wdw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             svc_we,
    input logic [CNT_W-1:0] svc_data,
    input logic             dbg_freeze,
    input logic             tick,
    input logic [CNT_W-1:0] wd_count,
    input logic             wd_locked,
    input logic             err_early,
    input logic             err_late,
    input logic             err_data,
    input logic             wd_err,
    input logic [CNT_W-1:0] cur_preload,
    input logic [CNT_W-1:0] cur_window,
    input logic [CNT_W-1:0] cur_match
);
    logic cfg_taken;
    assign cfg_taken = cfg_we && !wd_locked;

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick && !dbg_freeze && !svc_we && !cfg_taken && wd_count != '0
        |=> wd_count == CNT_W'($past(wd_count) - 1'b1));

    assert_good_service_R3: assert property (@(posedge clk) disable iff (rst)
        svc_we && wd_count <= cur_window && svc_data == cur_match && !wd_err
        |=> wd_count == $past(cur_preload) && !wd_err);

    assert_early_flag_R4: assert property (@(posedge clk) disable iff (rst)
        svc_we && wd_count > cur_window |=> err_early);

    assert_data_flag_R5: assert property (@(posedge clk) disable iff (rst)
        svc_we && svc_data != cur_match |=> err_data);

    assert_late_flag_R7: assert property (@(posedge clk) disable iff (rst)
        tick && !dbg_freeze && !svc_we && !cfg_taken && wd_count == '0
        |=> err_late && wd_count == $past(cur_preload));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err_early || err_late || err_data) |=> wd_err);

    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (rst)
        wd_locked |=> wd_locked && $stable(cur_preload) && $stable(cur_window)
                      && $stable(cur_match));

    assert_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        dbg_freeze && !svc_we && !cfg_taken |=> $stable(wd_count));
endmodule

bind wdw_top wdw_checker chk_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .svc_we(svc_we), .svc_data(svc_data),
    .dbg_freeze(dbg_freeze), .tick(tick), .wd_count(wd_count),
    .wd_locked(wd_locked), .err_early(err_early), .err_late(err_late),
    .err_data(err_data), .wd_err(wd_err), .cur_preload(cur_preload),
    .cur_window(cur_window), .cur_match(cur_match)
);

// File: tb/wdw_top_tb.sv
module wdw_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0, cfg_lock = 1'b0, svc_we = 1'b0, dbg_freeze = 1'b0;
    logic [7:0] cfg_preload = '0, cfg_window = '0, cfg_match = '0, svc_data = '0;
    logic [1:0] cfg_tick_sel = '0;
    logic [7:0] wd_count;
    logic       wd_locked, err_early, err_late, err_data, wd_err;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    wdw_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_preload(cfg_preload),
        .cfg_window(cfg_window), .cfg_match(cfg_match), .cfg_tick_sel(cfg_tick_sel),
        .cfg_lock(cfg_lock), .svc_we(svc_we), .svc_data(svc_data),
        .dbg_freeze(dbg_freeze), .wd_count(wd_count), .wd_locked(wd_locked),
        .err_early(err_early), .err_late(err_late), .err_data(err_data),
        .wd_err(wd_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flags_are(input string req, input int e, input int l, input int d);
        check({req, " early"}, int'(err_early), e);
        check({req, " late"}, int'(err_late), l);
        check({req, " data"}, int'(err_data), d);
        check({req, " wd_err"}, int'(wd_err), int'((e | l | d) != 0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] p, input logic [7:0] w,
                             input logic [7:0] m, input logic [1:0] s, input logic l);
        cfg_we = 1'b1; cfg_preload = p; cfg_window = w; cfg_match = m;
        cfg_tick_sel = s; cfg_lock = l;
        wait_n(1);
        cfg_we = 1'b0;
    endtask

    task automatic service(input logic [7:0] d);
        svc_we = 1'b1; svc_data = d;
        wait_n(1);
        svc_we = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check("R1 count", int'(wd_count), 255);
        check("R1 locked", int'(wd_locked), 0);
        flags_are("R1", 0, 0, 0);
        rst = 1'b0;
    endtask

    task automatic t_count_and_service();
        write_cfg(8'd20, 8'd10, 8'h5A, 2'd0, 1'b0);
        check("R9 load", int'(wd_count), 20);
        wait_n(5);
        check("R2 step", int'(wd_count), 15);
        wait_n(6);
        check("R2 step", int'(wd_count), 9);
        service(8'h5A);
        check("R3 reload", int'(wd_count), 20);
        flags_are("R3", 0, 0, 0);
    endtask

    task automatic t_prescale_freeze();
        write_cfg(8'd30, 8'd10, 8'h5A, 2'd2, 1'b0);
        wait_n(3);
        check("R2 sel2 hold", int'(wd_count), 30);
        wait_n(1);
        check("R2 sel2 step", int'(wd_count), 29);
        wait_n(4);
        check("R2 sel2 step", int'(wd_count), 28);
        dbg_freeze = 1'b1;
        wait_n(10);
        check("R11 frozen", int'(wd_count), 28);
        dbg_freeze = 1'b0;
        wait_n(3);
        check("R11 phase kept", int'(wd_count), 28);
        wait_n(1);
        check("R11 resume", int'(wd_count), 27);
    endtask

    task automatic t_early();
        do_reset();
        write_cfg(8'd20, 8'd10, 8'h5A, 2'd0, 1'b0);
        service(8'h5A);
        check("R4 reload", int'(wd_count), 20);
        flags_are("R4", 1, 0, 0);
        wait_n(3);
        flags_are("R8 sticky", 1, 0, 0);
    endtask

    task automatic t_data();
        do_reset();
        write_cfg(8'd20, 8'd10, 8'h5A, 2'd0, 1'b0);
        wait_n(12);
        check("R5 pre", int'(wd_count), 8);
        service(8'h33);
        check("R5 reload", int'(wd_count), 20);
        flags_are("R5", 0, 0, 1);
    endtask

    task automatic t_both();
        do_reset();
        write_cfg(8'd20, 8'd10, 8'h5A, 2'd0, 1'b0);
        service(8'h33);
        flags_are("R6", 1, 0, 1);
    endtask

    task automatic t_late();
        do_reset();
        write_cfg(8'd5, 8'd5, 8'h5A, 2'd0, 1'b0);
        wait_n(5);
        check("R7 zero", int'(wd_count), 0);
        flags_are("R7 before", 0, 0, 0);
        wait_n(1);
        check("R7 reload", int'(wd_count), 5);
        flags_are("R7", 0, 1, 0);
        wait_n(3);
        check("R8 count", int'(wd_count), 2);
        flags_are("R8 sticky", 0, 1, 0);
    endtask

    task automatic t_lock();
        do_reset();
        write_cfg(8'd20, 8'd10, 8'h5A, 2'd0, 1'b1);
        check("R9 lock set", int'(wd_locked), 1);
        wait_n(2);
        write_cfg(8'd50, 8'd50, 8'h11, 2'd0, 1'b0);
        check("R10 count kept", int'(wd_count), 17);
        check("R10 still locked", int'(wd_locked), 1);
        wait_n(8);
        service(8'h5A);
        check("R10 old preload", int'(wd_count), 20);
        flags_are("R10 old key", 0, 0, 0);
        do_reset();
        check("R10 reset unlocks", int'(wd_locked), 0);
    endtask

    initial begin
        t_reset_state();
        t_count_and_service();
        t_prescale_freeze();
        t_early();
        t_data();
        t_both();
        t_late();
        t_lock();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule